// File: doc/BRIEF.md
# Serial Debug Shift and Execute Port

This block is a test and debug access port run by a few control inputs. A 32-bit scan register is loaded and unloaded one bit per cycle through a serial input and a serial output. On request, its contents are decoded as a command that works on a small bank of 16-bit debug registers. A write command copies a data field into a selected register. A read command copies a selected register back into the scan register, which then shifts it out.

Each control input is first captured in a register and acts only in the following clock cycle. This gives every control wire a full cycle of propagation. The port acts only when it is selected, through an active-low select, and hold is asserted. Hold must be raised before any shift or execute activity starts. A registered functional reset clears the port, and so does an asynchronous active-low reset.

Top module: `dbg_scan_port`

## Requirements
- R1: Every control input (tap_rst, tap_hold, tap_shift, tap_exec, tap_sel_n, tap_din) is captured at one rising edge and takes effect at the next. A shift pulse driven for one cycle leaves tap_dout unchanged at the capture edge and updates it one edge later.
- R2: When a shift is captured with tap_sel_n low and tap_hold high, the scan register moves one place toward bit 0. The captured tap_din enters bit 31. Shifting a word in over 32 cycles, bit 0 first, leaves that word in the register.
- R3: tap_dout takes the bit that left bit 0 at the edge where the shift acts. It then stays unchanged until the next shift acts.
- R4: When tap_sel_n is captured high, captured shift and execute have no effect. The scan register, tap_dout and the debug registers keep their values.
- R5: When tap_hold is captured low, captured shift and execute have no effect. The scan register, tap_dout and the debug registers keep their values.
- R6: An execute with opcode bits [31:30] = 01 writes scan bits [15:0] into the debug register whose index is in bits [29:28].
- R7: An execute with opcode 10 copies the debug register indexed by bits [29:28] into scan bits [15:0]. Bits [31:16] are unchanged.
- R8: An execute with opcode 00 or 11 changes neither the scan register nor any debug register.
- R9: When shift and execute are captured in the same cycle, only the shift happens and no command is decoded.
- R10: A captured tap_rst clears the scan register, every debug register and tap_dout to zero. It wins over a shift or execute captured in the same cycle.
- R11: rst_n low clears the scan register, the debug registers, tap_dout and the captured controls at once. While rst_n is low, the captured select is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_rst | input | 1 | Functional reset request, acts one cycle after capture |
| tap_hold | input | 1 | Hold; must be high for shift or execute to act |
| tap_shift | input | 1 | Shift the scan register by one bit |
| tap_exec | input | 1 | Decode the scan register as a command |
| tap_sel_n | input | 1 | Active-low port select |
| tap_din | input | 1 | Serial data in, enters bit 31 |
| tap_dout | output | 1 | Serial data out, the last bit shifted out of bit 0 |

## Verification
Shift is tried with a single isolated pulse, which separates the capture edge from the acting edge and shows the output holding afterwards. Whole alternating and half-filled words are then shifted through, which exposes wrong bit order or a dropped bit. Execute is tried with all four opcodes, two distinct register indices and a register never written, which tells apart a wrong index decode, a clobbered upper field and a command that should be inert. Shift and execute are also driven while deselected, without hold, together in one cycle, and together with a functional reset, and each is read back through the serial path to show which operation won.

// File: rtl/dbg_port_pkg.sv
package dbg_port_pkg;

  typedef enum logic [1:0] {
    OP_NOP = 2'b00,
    OP_WR  = 2'b01,
    OP_RD  = 2'b10,
    OP_RSV = 2'b11
  } dbg_op_e;

  typedef struct packed {
    logic rst;
    logic hold;
    logic shift;
    logic exec;
    logic sel_n;
    logic din;
  } dbg_ctl_t;

  localparam dbg_ctl_t CTL_IDLE = '{rst: 1'b0, hold: 1'b0, shift: 1'b0,
                                    exec: 1'b0, sel_n: 1'b1, din: 1'b0};

endpackage

// File: rtl/dbg_in_capture.sv
module dbg_in_capture
  import dbg_port_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  dbg_ctl_t ctl_in,
  output dbg_ctl_t ctl_q
);

  dbg_ctl_t ctl_d;

  always_comb begin
    ctl_d = ctl_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_IDLE;
    end else begin
      ctl_q <= ctl_d;
    end
  end

endmodule

// File: rtl/dbg_shift_path.sv
module dbg_shift_path #(
  parameter int SR_W = 32,
  parameter int LD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            shift_en,
  input  logic            din,
  input  logic            load_en,
  input  logic [LD_W-1:0] load_data,
  output logic [SR_W-1:0] sr_q,
  output logic            dout_q
);

  logic [SR_W-1:0] sr_d;
  logic            dout_d;
  logic            sr_en;
  logic            dout_en;

  always_comb begin
    sr_d   = sr_q;
    dout_d = dout_q;
    if (clr) begin
      sr_d   = '0;
      dout_d = 1'b0;
    end else if (shift_en) begin
      sr_d   = {din, sr_q[SR_W-1:1]};
      dout_d = sr_q[0];
    end else if (load_en) begin
      sr_d[LD_W-1:0] = load_data;
    end
  end

  assign sr_en   = clr | shift_en | load_en;
  assign dout_en = clr | shift_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= 1'b0;
    end else if (dout_en) begin
      dout_q <= dout_d;
    end
  end

endmodule

// File: rtl/dbg_cmd_bank.sv
module dbg_cmd_bank
  import dbg_port_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREG   = 4,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              exec_en,
  input  dbg_op_e           op,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              load_en,
  output logic [DATA_W-1:0] load_data
);

  logic [DATA_W-1:0] regs_q [NREG];
  logic              wr_cmd;

  assign wr_cmd    = exec_en & (op == OP_WR);
  assign load_en   = exec_en & (op == OP_RD);
  assign load_data = regs_q[idx];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic              hit;
    logic              en;
    logic [DATA_W-1:0] nxt;

    assign hit = wr_cmd & (idx == IDX_W'(g));
    assign en  = clr | hit;

    always_comb begin
      nxt = regs_q[g];
      if (clr) begin
        nxt = '0;
      end else if (hit) begin
        nxt = wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (en) begin
        regs_q[g] <= nxt;
      end
    end
  end

endmodule

// File: rtl/dbg_scan_port.sv
module dbg_scan_port
  import dbg_port_pkg::*;
#(
  parameter int SR_W   = 32,
  parameter int DATA_W = 16,
  parameter int NREG   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tap_rst,
  input  logic tap_hold,
  input  logic tap_shift,
  input  logic tap_exec,
  input  logic tap_sel_n,
  input  logic tap_din,
  output logic tap_dout
);

  localparam int IDX_W  = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int OP_MSB = SR_W - 1;
  localparam int IX_MSB = SR_W - 3;

  dbg_ctl_t          ctl_in;
  dbg_ctl_t          ctl_q;
  logic              active;
  logic              shift_go;
  logic              exec_go;
  logic [SR_W-1:0]   sr_q;
  logic              load_en;
  logic [DATA_W-1:0] load_data;
  dbg_op_e           op;
  logic [IDX_W-1:0]  idx;

  assign ctl_in = '{rst: tap_rst, hold: tap_hold, shift: tap_shift,
                    exec: tap_exec, sel_n: tap_sel_n, din: tap_din};

  dbg_in_capture u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl_in (ctl_in),
    .ctl_q  (ctl_q)
  );

  assign active   = ctl_q.hold & ~ctl_q.sel_n & ~ctl_q.rst;
  assign shift_go = active & ctl_q.shift;
  assign exec_go  = active & ctl_q.exec & ~ctl_q.shift;

  assign op  = dbg_op_e'(sr_q[OP_MSB -: 2]);
  assign idx = sr_q[IX_MSB -: IDX_W];

  dbg_shift_path #(
    .SR_W (SR_W),
    .LD_W (DATA_W)
  ) u_sr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ctl_q.rst),
    .shift_en  (shift_go),
    .din       (ctl_q.din),
    .load_en   (load_en),
    .load_data (load_data),
    .sr_q      (sr_q),
    .dout_q    (tap_dout)
  );

  dbg_cmd_bank #(
    .DATA_W (DATA_W),
    .NREG   (NREG)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ctl_q.rst),
    .exec_en   (exec_go),
    .op        (op),
    .idx       (idx),
    .wdata     (sr_q[DATA_W-1:0]),
    .load_en   (load_en),
    .load_data (load_data)
  );

endmodule

// File: rtl/dbg_scan_port_chk.sv
module dbg_scan_port_chk
  import dbg_port_pkg::*;
#(
  parameter int SR_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input dbg_ctl_t        ctl,
  input logic [SR_W-1:0] sr_q,
  input logic            dout
);

  // R10
  func_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.rst |=> (sr_q == '0 && dout == 1'b0));

  // R2
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.shift && ctl.hold && !ctl.sel_n && !ctl.rst)
    |=> sr_q == {$past(ctl.din), $past(sr_q[SR_W-1:1])});

  // R3
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.rst && !(ctl.shift && ctl.hold && !ctl.sel_n)) |=> $stable(dout));

  // R4
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.sel_n && !ctl.rst) |=> $stable(sr_q));

  // R5
  no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.hold && !ctl.rst) |=> $stable(sr_q));

  // R11
  always @(negedge clk) begin
    if (!rst_n) begin
      async_clear_chk: assert (sr_q == '0 && dout == 1'b0 && ctl.sel_n);
    end
  end

endmodule

bind dbg_scan_port dbg_scan_port_chk #(.SR_W(SR_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .ctl   (ctl_q),
  .sr_q  (sr_q),
  .dout  (tap_dout)
);

// File: tb/sim_dbg_scan_port.sv
module sim_dbg_scan_port;

  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic tap_rst, tap_hold, tap_shift, tap_exec, tap_sel_n, tap_din;
  logic tap_dout;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dbg_scan_port u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tap_rst   (tap_rst),
    .tap_hold  (tap_hold),
    .tap_shift (tap_shift),
    .tap_exec  (tap_exec),
    .tap_sel_n (tap_sel_n),
    .tap_din   (tap_din),
    .tap_dout  (tap_dout)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scan(input logic [31:0] win, output logic [31:0] wout);
    for (int i = 0; i < 32; i++) begin
      tap_shift = 1'b1;
      tap_din   = win[i];
      @(negedge clk);
      if (i > 0) wout[i-1] = tap_dout;
    end
    tap_shift = 1'b0;
    tap_din   = 1'b0;
    @(negedge clk);
    wout[31] = tap_dout;
  endtask

  task automatic pulse_exec();
    tap_exec = 1'b1;
    @(negedge clk);
    tap_exec = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_reg(input logic [1:0] ix, input logic [15:0] d);
    logic [31:0] tmp;
    scan({2'b01, ix, 12'hA5C, d}, tmp);
    pulse_exec();
  endtask

  task automatic read_reg(input logic [1:0] ix, output logic [31:0] w);
    logic [31:0] tmp;
    scan({2'b10, ix, 12'h000, 16'h0000}, tmp);
    pulse_exec();
    scan(32'h0, w);
  endtask

  task automatic t_reset_state();
    logic [31:0] w;
    chk("R11 dout after async reset", {31'b0, tap_dout}, 32'h0);
    scan(32'h0, w);
    chk("R11 scan register after async reset", w, 32'h0);
    read_reg(2'd2, w);
    chk("R11 debug register after async reset", {16'h0, w[15:0]}, 32'h0);
  endtask

  task automatic t_latency();
    logic [31:0] w;
    scan(32'h0000_0001, w);
    tap_shift = 1'b1;
    @(negedge clk);
    tap_shift = 1'b0;
    chk("R1 dout unchanged at capture edge", {31'b0, tap_dout}, 32'h0);
    @(negedge clk);
    chk("R3 dout updated at acting edge", {31'b0, tap_dout}, 32'h1);
    @(negedge clk);
    @(negedge clk);
    chk("R3 dout held with no shift", {31'b0, tap_dout}, 32'h1);
  endtask

  task automatic t_shift_pattern();
    logic [31:0] w;
    scan(32'hA5A5_3C3C, w);
    scan(32'hFFFF_0000, w);
    chk("R2 word shifted through", w, 32'hA5A5_3C3C);
    scan(32'h8000_0001, w);
    chk("R2 second word shifted through", w, 32'hFFFF_0000);
    chk("R3 dout is last bit out", {31'b0, tap_dout}, {31'b0, 1'b1});
  endtask

  task automatic t_write_read();
    logic [31:0] w;
    write_reg(2'd0, 16'h1234);
    write_reg(2'd3, 16'hBEEF);
    read_reg(2'd3, w);
    chk("R7 read reg3 keeps upper field", w, {2'b10, 2'd3, 12'h000, 16'hBEEF});
    read_reg(2'd0, w);
    chk("R6 write then read reg0", {16'h0, w[15:0]}, 32'h1234);
    read_reg(2'd1, w);
    chk("R6 unwritten reg1 stays zero", {16'h0, w[15:0]}, 32'h0);
  endtask

  task automatic t_inert_ops();
    logic [31:0] w;
    scan({2'b00, 2'd0, 12'h000, 16'h5555}, w);
    pulse_exec();
    scan(32'h0, w);
    chk("R8 opcode 00 leaves scan register", w, {2'b00, 2'd0, 12'h000, 16'h5555});
    scan({2'b11, 2'd0, 12'h000, 16'h6666}, w);
    pulse_exec();
    scan(32'h0, w);
    chk("R8 opcode 11 leaves scan register", w, {2'b11, 2'd0, 12'h000, 16'h6666});
    read_reg(2'd0, w);
    chk("R8 reg0 untouched by 00/11", {16'h0, w[15:0]}, 32'h1234);
  endtask

  task automatic t_gated(input bit use_sel);
    logic [31:0] w;
    logic [31:0] cmd;
    logic        d0;
    string       req;
    req = use_sel ? "R4" : "R5";
    cmd = {2'b01, 2'd0, 12'h000, 16'hDEAD};
    scan(cmd, w);
    d0 = tap_dout;
    if (use_sel) tap_sel_n = 1'b1; else tap_hold = 1'b0;
    pulse_exec();
    tap_shift = 1'b1;
    tap_din   = 1'b1;
    @(negedge clk);
    tap_shift = 1'b0;
    tap_din   = 1'b0;
    tap_sel_n = 1'b0;
    tap_hold  = 1'b1;
    @(negedge clk);
    chk({req, " dout unchanged while gated"}, {31'b0, tap_dout}, {31'b0, d0});
    scan(32'h0, w);
    chk({req, " scan register unchanged while gated"}, w, cmd);
    read_reg(2'd0, w);
    chk({req, " reg0 not written while gated"}, {16'h0, w[15:0]}, 32'h1234);
  endtask

  task automatic t_shift_and_exec();
    logic [31:0] w;
    logic [31:0] cmd;
    cmd = {2'b01, 2'd1, 12'h000, 16'h7777};
    scan(cmd, w);
    tap_shift = 1'b1;
    tap_exec  = 1'b1;
    tap_din   = 1'b1;
    @(negedge clk);
    tap_shift = 1'b0;
    tap_exec  = 1'b0;
    tap_din   = 1'b0;
    @(negedge clk);
    scan(32'h0, w);
    chk("R9 only the shift happened", w, {1'b1, cmd[31:1]});
    read_reg(2'd1, w);
    chk("R9 reg1 not written", {16'h0, w[15:0]}, 32'h0);
  endtask

  task automatic t_func_reset();
    logic [31:0] w;
    write_reg(2'd2, 16'hAAAA);
    scan(32'hFFFF_FFFF, w);
    chk("R2 ones word prior state", {31'b0, tap_dout}, 32'h0);
    scan(32'hFFFF_FFFF, w);
    tap_rst   = 1'b1;
    tap_shift = 1'b1;
    tap_din   = 1'b1;
    @(negedge clk);
    tap_rst   = 1'b0;
    tap_shift = 1'b0;
    tap_din   = 1'b0;
    @(negedge clk);
    chk("R10 dout cleared over shift", {31'b0, tap_dout}, 32'h0);
    scan(32'h0, w);
    chk("R10 scan register cleared", w, 32'h0);
    read_reg(2'd2, w);
    chk("R10 reg2 cleared", {16'h0, w[15:0]}, 32'h0);
  endtask

  task automatic t_async_reset();
    logic [31:0] w;
    write_reg(2'd0, 16'h4321);
    scan(32'hFFFF_FFFF, w);
    scan(32'hFFFF_FFFF, w);
    #(CLK_PERIOD / 4);
    rst_n = 1'b0;
    #(CLK_PERIOD / 8);
    chk("R11 dout cleared at once", {31'b0, tap_dout}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_reg(2'd0, w);
    chk("R11 reg0 cleared by async reset", {16'h0, w[15:0]}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    tap_rst   = 1'b0;
    tap_hold  = 1'b1;
    tap_shift = 1'b0;
    tap_exec  = 1'b0;
    tap_sel_n = 1'b0;
    tap_din   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_latency();
    t_shift_pattern();
    t_write_read();
    t_inert_ops();
    t_gated(1'b1);
    t_gated(1'b0);
    t_shift_and_exec();
    t_func_reset();
    t_async_reset();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule